// File: doc/BRIEF.md
# Receive Packet Descriptor Writer

This block sits at the end of a multi-channel packet receive path. Each time a data buffer has been filled, the upstream logic presents one request. The request carries the buffer's start address, the number of bytes stored in it, the channel number (1 to NUM_CH), an end-of-packet flag, the chain index of the next descriptor, and the word address at which this descriptor is to be placed. The block formats a four-word descriptor and writes words 0, 1 and 2 over a simple word-write memory port with valid/ready flow control. Word 3 is left for the host and is never written.

A per-channel flag records whether a packet is open on that channel. The block uses this flag to mark each buffer as the first, a middle, or the last buffer of its packet, with a one-hot code. A free-running timestamp advances once every TS_DIV clock cycles. The block samples it at the moment it accepts a request and stores it in the descriptor, so the host can measure gaps between packet arrivals. A byte count above the legal maximum is clipped, and a one-cycle error pulse is raised for that descriptor.

Top module: `rx_desc_writer`

## Requirements
- R1: Word 0 of the descriptor, written to the descriptor address, equals the 32-bit buffer start address.
- R2: Word 1 bits [15:0] carry the next-descriptor index when the status is first (001) or middle (010), and are zero when the status is last (100).
- R3: Word 1 bits [28:16] carry the byte count. A count above 8188 is written as 8188, and `cnt_err` is high for exactly the one cycle after that request is accepted. In every other cycle `cnt_err` is low.
- R4: Word 1 bits [31:29] carry the status, tracked separately for each channel. The code is 001 when no packet is open on the channel and end-of-packet is low. It is 010 when a packet is open and end-of-packet is low. It is 100 whenever end-of-packet is high. A last buffer closes the packet.
- R5: Word 2 bits [7:0] carry the channel number minus one, zero-extended (channel 1 gives 0x00).
- R6: Word 2 bits [31:8] carry the timestamp, zero-extended from TS_W bits. Its value is floor(n / TS_DIV) mod 2^TS_W, where n is the number of clock edges after reset before the accepting edge.
- R7: Words 0, 1 and 2 are written in that order to the descriptor address plus 0, 1 and 2. The address plus 3 is never written.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values into the next cycle.
- R9: After reset, `in_ready` is high, `mem_valid` is low and `cnt_err` is low. `in_ready` goes low in the cycle after a request is accepted and returns high only after word 2 has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Buffer request present |
| in_ready | output | 1 | Block idle; request accepted when both are high |
| in_buf_addr | input | 32 | Data buffer start address |
| in_byte_cnt | input | BC_IN_W | Bytes stored in the buffer |
| in_chan | input | CH_W+1 | Channel number, 1 to NUM_CH |
| in_eop | input | 1 | This buffer closes its packet |
| in_next_idx | input | 16 | Chain index of the next descriptor |
| in_desc_addr | input | AW | Word address of this descriptor |
| mem_valid | output | 1 | Write word present |
| mem_ready | input | 1 | Memory takes the word |
| mem_addr | output | AW | Word address of the write |
| mem_data | output | 32 | Write data |
| cnt_err | output | 1 | Byte count was clipped |

## Verification
The bench builds the block with NUM_CH=4, TS_W=6, TS_DIV=16, AW=8 and BC_IN_W=16. Four channels let the bench sweep every status sequence (single, two-buffer and three-buffer packets) on all channels, with the buffers of different channels interleaved. A 6-bit timestamp wraps every 1024 cycles, so the wrap to zero is checked within a short run. The 16-bit count input reaches the clip boundary at 8188 and 8189 as well as the all-ones count, and a stalling ready pattern checks that each word is held on the port until it is taken.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam logic [2:0] ST_FIRST = 3'b001;
  localparam logic [2:0] ST_MID   = 3'b010;
  localparam logic [2:0] ST_LAST  = 3'b100;
  typedef enum logic [1:0] {S_IDLE, S_W0, S_W1, S_W2} wr_state_e;
endpackage

// File: rtl/rxd_ts_gen.sv
module rxd_ts_gen #(
  parameter int TS_DIV = 16,
  parameter int TS_W   = 24
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] ts
);
  localparam int PW = (TS_DIV > 1) ? $clog2(TS_DIV) : 1;
  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= '0;
      ts  <= '0;
    end else if (pre == PW'(TS_DIV - 1)) begin
      pre <= '0;
      ts  <= ts + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  // R6: timestamp only ever steps by one (with wrap)
  p_ts_step_r6: assert property (@(posedge clk) disable iff (rst)
    (ts != $past(ts)) |-> (ts == $past(ts) + 1'b1));
endmodule

// File: rtl/rxd_pkt_track.sv
module rxd_pkt_track #(
  parameter int NUM_CH = 256,
  parameter int CH_W   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd,
  input  logic [CH_W-1:0] ch_idx,
  input  logic            eop,
  output logic [2:0]      status
);
  import rxd_pkg::*;
  logic [NUM_CH-1:0] open_q;

  always_comb begin
    if (eop)                 status = ST_LAST;
    else if (open_q[ch_idx]) status = ST_MID;
    else                     status = ST_FIRST;
  end

  always_ff @(posedge clk) begin
    if (rst)      open_q <= '0;
    else if (upd) open_q[ch_idx] <= !eop;
  end

  // R4: status code is one-hot whenever it is used
  p_status_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    upd |-> $onehot(status));
  // R4: a last buffer closes the channel's packet
  p_close_r4: assert property (@(posedge clk) disable iff (rst)
    (upd && eop) |=> !open_q[$past(ch_idx)]);
endmodule

// File: rtl/rxd_word_pack.sv
module rxd_word_pack #(
  parameter int CH_W      = 8,
  parameter int TS_W      = 24,
  parameter int BC_IN_W   = 16,
  parameter int MAX_BYTES = 8188
) (
  input  logic [31:0]        buf_addr,
  input  logic [BC_IN_W-1:0] byte_cnt,
  input  logic [15:0]        next_idx,
  input  logic [CH_W-1:0]    ch_idx,
  input  logic [TS_W-1:0]    ts,
  input  logic [2:0]         status,
  output logic [31:0]        w0,
  output logic [31:0]        w1,
  output logic [31:0]        w2,
  output logic               clip
);
  import rxd_pkg::*;
  logic [12:0] bc_f;
  logic [15:0] link;

  always_comb begin
    clip = byte_cnt > BC_IN_W'(MAX_BYTES);
    bc_f = clip ? 13'(MAX_BYTES) : 13'(byte_cnt);
    link = (status == ST_LAST) ? 16'h0000 : next_idx;
    w0   = buf_addr;
    w1   = {status, bc_f, link};
    w2   = {24'(ts), 8'(ch_idx)};
  end
endmodule

// File: rtl/rx_desc_writer.sv
module rx_desc_writer #(
  parameter int NUM_CH    = 256,
  parameter int CH_W      = 8,
  parameter int TS_W      = 24,
  parameter int TS_DIV    = 16,
  parameter int BC_IN_W   = 16,
  parameter int AW        = 32,
  parameter int MAX_BYTES = 8188
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_buf_addr,
  input  logic [BC_IN_W-1:0] in_byte_cnt,
  input  logic [CH_W:0]      in_chan,
  input  logic               in_eop,
  input  logic [15:0]        in_next_idx,
  input  logic [AW-1:0]      in_desc_addr,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [AW-1:0]      mem_addr,
  output logic [31:0]        mem_data,
  output logic               cnt_err
);
  import rxd_pkg::*;

  wr_state_e        state;
  logic [TS_W-1:0]  ts;
  logic [2:0]       status;
  logic [CH_W-1:0]  ch_idx;
  logic [31:0]      w0, w1, w2, w1_q, w2_q;
  logic             clip, accept;
  logic [AW-1:0]    base_q, offs;

  assign ch_idx   = CH_W'(in_chan - 1'b1);
  assign in_ready = (state == S_IDLE);
  assign accept   = in_valid && in_ready;

  rxd_ts_gen #(.TS_DIV(TS_DIV), .TS_W(TS_W)) u_ts (
    .clk(clk), .rst(rst), .ts(ts));

  rxd_pkt_track #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_trk (
    .clk(clk), .rst(rst), .upd(accept), .ch_idx(ch_idx),
    .eop(in_eop), .status(status));

  rxd_word_pack #(.CH_W(CH_W), .TS_W(TS_W), .BC_IN_W(BC_IN_W),
                  .MAX_BYTES(MAX_BYTES)) u_pack (
    .buf_addr(in_buf_addr), .byte_cnt(in_byte_cnt), .next_idx(in_next_idx),
    .ch_idx(ch_idx), .ts(ts), .status(status),
    .w0(w0), .w1(w1), .w2(w2), .clip(clip));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      mem_valid <= 1'b0;
      cnt_err   <= 1'b0;
    end else begin
      cnt_err <= 1'b0;
      case (state)
        S_IDLE: if (in_valid) begin
          state     <= S_W0;
          mem_valid <= 1'b1;
          mem_addr  <= in_desc_addr;
          mem_data  <= w0;
          base_q    <= in_desc_addr;
          w1_q      <= w1;
          w2_q      <= w2;
          cnt_err   <= clip;
        end
        S_W0: if (mem_ready) begin
          state    <= S_W1;
          mem_addr <= mem_addr + 1'b1;
          mem_data <= w1_q;
        end
        S_W1: if (mem_ready) begin
          state    <= S_W2;
          mem_addr <= mem_addr + 1'b1;
          mem_data <= w2_q;
        end
        default: if (mem_ready) begin
          state     <= S_IDLE;
          mem_valid <= 1'b0;
        end
      endcase
    end
  end

  assign offs = mem_addr - base_q;

  // R8: a stalled word is held unchanged
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));
  // R7: consecutive words go to consecutive addresses
  p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && state != S_W2) |=> (mem_addr == $past(mem_addr) + 1'b1));
  // R7: the fourth word is never addressed
  p_no_w3_r7: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (offs < AW'(3)));
  // R3: error pulse only follows an accepted request
  p_err_src_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_err |-> $past(accept));
  // R9: busy right after accepting
  p_busy_r9: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!in_ready && mem_valid));
endmodule

// File: tb/tb_rx_desc_writer.sv
`timescale 1ns/1ps
module tb_rx_desc_writer;
  localparam int NUM_CH = 4, CH_W = 2, TS_W = 6, TS_DIV = 16, BC_IN_W = 16, AW = 8;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_eop = 0;
  logic [31:0] in_buf_addr = 0;
  logic [BC_IN_W-1:0] in_byte_cnt = 0;
  logic [CH_W:0] in_chan = 1;
  logic [15:0] in_next_idx = 0;
  logic [AW-1:0] in_desc_addr = 0;
  logic in_ready, mem_valid, cnt_err;
  logic mem_ready = 0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_data;

  int checks = 0, errors = 0, cyc = 0, rc = 0, nsend = 0;
  bit stall_en = 0, prev_stall = 0;
  logic [AW-1:0] pa;
  logic [31:0] pd;
  logic [31:0] mem [0:255];
  bit wr [0:255];
  bit open_m [1:NUM_CH];

  rx_desc_writer #(.NUM_CH(NUM_CH), .CH_W(CH_W), .TS_W(TS_W), .TS_DIV(TS_DIV),
                   .BC_IN_W(BC_IN_W), .AW(AW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_buf_addr(in_buf_addr), .in_byte_cnt(in_byte_cnt), .in_chan(in_chan),
    .in_eop(in_eop), .in_next_idx(in_next_idx), .in_desc_addr(in_desc_addr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .cnt_err(cnt_err));

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: picks ready, checks holding, records handshakes
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        chk(mem_valid && mem_addr == pa && mem_data == pd, "R8", "held word",
            mem_data, pd);
      end
      rc++;
      mem_ready = stall_en ? (rc % 3 == 0) : 1'b1;
      prev_stall = mem_valid && !mem_ready;
      pa = mem_addr;
      pd = mem_data;
      if (mem_valid && mem_ready) begin
        mem[mem_addr] = mem_data;
        wr[mem_addr] = 1'b1;
      end
    end
  end

  task automatic send(input int ch, input bit eop, input int bc, input bit stall);
    int t, base, waitc;
    logic [31:0] ba;
    logic [15:0] nx;
    logic [2:0] st;
    int ebc;
    logic [15:0] elink;
    base = (nsend % 60) * 4;
    ba = 32'hA000_0000 + (ch << 20) + nsend * 64;
    nx = 16'(nsend * 7 + ch) ^ 16'h5A5A;
    nsend++;
    @(negedge clk);
    stall_en = stall;
    for (int k = 0; k < 4; k++) wr[base + k] = 1'b0;
    in_chan = (CH_W+1)'(ch);
    in_eop = eop;
    in_byte_cnt = BC_IN_W'(bc);
    in_buf_addr = ba;
    in_next_idx = nx;
    in_desc_addr = AW'(base);
    in_valid = 1'b1;
    t = cyc;
    chk(in_ready == 1'b1, "R9", "ready before send", {31'b0, in_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R9", "busy after accept", {31'b0, in_ready}, 32'd0);
    chk(cnt_err == (bc > 8188), "R3", "error pulse", {31'b0, cnt_err}, {31'b0, bc > 8188});
    waitc = 0;
    while (!in_ready && waitc < 50) begin @(negedge clk); waitc++; end
    chk(cnt_err == 1'b0, "R3", "error low later", {31'b0, cnt_err}, 32'd0);
    st = eop ? 3'b100 : (open_m[ch] ? 3'b010 : 3'b001);
    open_m[ch] = !eop;
    ebc = (bc > 8188) ? 8188 : bc;
    elink = (st == 3'b100) ? 16'h0 : nx;
    chk(wr[base] && wr[base+1] && wr[base+2], "R7", "words 0..2 written",
        {29'b0, wr[base], wr[base+1], wr[base+2]}, 32'd7);
    chk(!wr[base+3], "R7", "word 3 untouched", {31'b0, wr[base+3]}, 32'd0);
    chk(mem[base] == ba, "R1", "buffer address", mem[base], ba);
    chk(mem[base+1][15:0] == elink, "R2", "next index", {16'b0, mem[base+1][15:0]}, {16'b0, elink});
    chk(mem[base+1][28:16] == 13'(ebc), "R3", "byte count",
        {19'b0, mem[base+1][28:16]}, 32'(ebc));
    chk(mem[base+1][31:29] == st, "R4", "status", {29'b0, mem[base+1][31:29]}, {29'b0, st});
    chk(mem[base+2][7:0] == 8'(ch - 1), "R5", "channel field",
        {24'b0, mem[base+2][7:0]}, 32'(ch - 1));
    chk(mem[base+2][31:8] == 24'((t / TS_DIV) % (1 << TS_W)), "R6", "timestamp",
        {8'b0, mem[base+2][31:8]}, 32'((t / TS_DIV) % (1 << TS_W)));
  endtask

  initial begin
    for (int c = 1; c <= NUM_CH; c++) open_m[c] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9", "reset ready", {31'b0, in_ready}, 32'd1);
    chk(mem_valid == 1'b0, "R9", "reset mem_valid", {31'b0, mem_valid}, 32'd0);
    chk(cnt_err == 1'b0, "R9", "reset cnt_err", {31'b0, cnt_err}, 32'd0);
    // packets of one, two and three buffers, channels interleaved
    for (int len = 1; len <= 3; len++)
      for (int b = 0; b < len; b++)
        for (int ch = 1; ch <= NUM_CH; ch++)
          send(ch, b == len - 1, (ch * 1237 + b * 811 + len * 97) % 8189, (ch + b) % 2 == 1);
    // byte-count boundaries on a single-buffer packet
    send(2, 1, 0, 0);
    send(3, 1, 8188, 1);
    send(4, 1, 8189, 0);
    send(1, 1, 16'hFFFF, 1);
    // clipped count inside a multi-buffer packet
    send(1, 0, 9000, 0);
    send(1, 0, 8190, 1);
    send(1, 1, 40, 0);
    // let the 6-bit timestamp wrap
    repeat (1100) @(negedge clk);
    send(2, 0, 100, 1);
    repeat (700) @(negedge clk);
    send(2, 1, 200, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule